// File: doc/BRIEF.md
# Four-Lane Sobel Gradient Unit

This block is one stage of an edge-detection pipeline. It accepts a stream of already-smoothed 8-bit grey pixels, four pixels packed into each 32-bit word. For every word it works out the horizontal and vertical Sobel derivatives of the four pixels the word covers. It turns each pair into an 8-bit gradient magnitude and a 2-bit quantised edge direction. All four results come out in the same cycle. Only shifts, additions, subtractions and comparisons are used: no multiplier and no divider.

Two earlier image lines are kept in two packed-word line memories, each `IMG_W/4` words of 32 bits. The four 3x3 windows share one 3-row by 6-column window of 18 pixels. That window is built from the previous word column, the current one and the next one. Output starts as soon as one full line is cached. Any pixel that lies above, below, left of or right of the frame counts as black (value 0). Results leave in raster order, one line plus a short pipeline behind the input. After the frame's last word the block emits the final line by itself.

Top module: `sobel4_grad`

## Requirements
- R1: Each `out_valid` word carries four results for four horizontally adjacent pixels. Pixel k (k=0 is leftmost, 0..3) of a word sits in the following bits: input `in_data[8k+7:8k]`, output `out_mag[8k+7:8k]` and output `out_dir[2k+1:2k]`.
- R2: With P(dy,dx) the neighbour pixel, the derivatives are defined as follows. Gx = (P(-1,+1) + 2P(0,+1) + P(+1,+1)) - (P(-1,-1) + 2P(0,-1) + P(+1,-1)). Gy = (P(+1,-1) + 2P(+1,0) + P(+1,+1)) - (P(-1,-1) + 2P(-1,0) + P(-1,+1)). Magnitude is |Gx|+|Gy|, saturated at 255.
- R3: The direction code is chosen in this order. It is 0 (0 degrees) when 128|Gy| <= 53|Gx|. Otherwise it is 2 (90 degrees) when 128|Gy| >= 309|Gx|. Otherwise it is 1 (45 degrees) when Gx and Gy have the same sign, and 3 (135 degrees) when their signs differ.
- R4: Pixels outside the frame read as 0. This covers the row above the first line, the row below the last line, the pixel left of word 0 and the pixel right of the last word of a line.
- R5: Results appear in raster order, exactly one output word per input word. Nothing is output while the first line of a frame is arriving.
- R6: When a word with `in_eof` is accepted, the block emits the frame's last line over the next `IMG_W/4+1` cycles with no further input. `in_valid` must stay low during that time.
- R7: `in_sof` on a frame's first word restarts line counting. Lines cached from an earlier frame are never used as neighbours.
- R8: After reset `out_valid` is low and stays low until results are produced. `IMG_W` must be a multiple of 4 and at least 8. Every line ends with `in_eol` on its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_sof | input | 1 | First word of a frame |
| in_eol | input | 1 | Last word of a line |
| in_eof | input | 1 | Last word of a frame (together with in_eol) |
| in_data | input | 32 | Four packed 8-bit pixels |
| out_valid | output | 1 | Output word valid |
| out_mag | output | 32 | Four 8-bit gradient magnitudes |
| out_dir | output | 8 | Four 2-bit direction codes |

## Verification
The bench targets four kinds of corner case.

- **Frame borders.** A flat frame and step frames probe the black border on all four sides. A design that used stale line-memory contents, or wrapped a neighbouring word across the line end, would give non-zero or wrong magnitudes there.
- **Directions.** Diagonal and anti-diagonal ramps check the sector comparisons and the sign rule. A swapped sign test or a coarse threshold would report 45 where 135 (or 0) is expected.
- **Frame length and order.** Frames of one and two lines, and frames delivered with gaps in `in_valid`, exercise the self-driven flush and the shift between words. A design that dropped the flush, or misordered the output, would lose the last line or shift results by one word.
- **Frame restart and saturation.** A bright textured frame is followed directly by another frame, so a design that did not restart line counting would leak the old lines into the new top row. The same bright frame drives the magnitude into saturation.

// File: rtl/sobel4_pkg.sv
package sobel4_pkg;
    localparam int PIX_W = 8;
    localparam int LANES = 4;
    localparam int WORD_W = PIX_W * LANES;
    localparam int ROWS = 3;

    typedef enum logic [1:0] {
        DIR_0   = 2'd0,
        DIR_45  = 2'd1,
        DIR_90  = 2'd2,
        DIR_135 = 2'd3
    } dir_e;
endpackage

// File: rtl/s4_line_mem.sv
module s4_line_mem #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/s4_kernel.sv
module s4_kernel
    import sobel4_pkg::*;
(
    input  logic [PIX_W-1:0]  t0,
    input  logic [PIX_W-1:0]  t1,
    input  logic [PIX_W-1:0]  t2,
    input  logic [PIX_W-1:0]  m0,
    input  logic [PIX_W-1:0]  m2,
    input  logic [PIX_W-1:0]  b0,
    input  logic [PIX_W-1:0]  b1,
    input  logic [PIX_W-1:0]  b2,
    output logic [PIX_W-1:0]  mag,
    output dir_e              dir,
    output logic signed [11:0] gx,
    output logic signed [11:0] gy
);
    logic [9:0]  lsum, rsum, tsum, bsum;
    logic [10:0] ax, ay;
    logic [11:0] sum;
    logic [18:0] ax_w, lo_lim, hi_lim, ay_sc;

    always_comb begin
        // weighted column and row sums, x2 done by a shift
        lsum = {2'b0, t0} + {1'b0, m0, 1'b0} + {2'b0, b0};
        rsum = {2'b0, t2} + {1'b0, m2, 1'b0} + {2'b0, b2};
        tsum = {2'b0, t0} + {1'b0, t1, 1'b0} + {2'b0, t2};
        bsum = {2'b0, b0} + {1'b0, b1, 1'b0} + {2'b0, b2};
        gx = $signed({2'b0, rsum}) - $signed({2'b0, lsum});
        gy = $signed({2'b0, bsum}) - $signed({2'b0, tsum});
        ax = gx[11] ? (~gx[10:0] + 11'd1) : gx[10:0];
        ay = gy[11] ? (~gy[10:0] + 11'd1) : gy[10:0];
        sum = {1'b0, ax} + {1'b0, ay};
        mag = (sum > 12'd255) ? 8'hFF : sum[7:0];
        // 53/128 ~ tan(22.5), 309/128 ~ tan(67.5), built from shifts
        ax_w   = {8'b0, ax};
        lo_lim = (ax_w << 5) + (ax_w << 4) + (ax_w << 2) + ax_w;
        hi_lim = lo_lim + (ax_w << 8);
        ay_sc  = {8'b0, ay} << 7;
        if (ay_sc <= lo_lim) begin
            dir = DIR_0;
        end else if (ay_sc >= hi_lim) begin
            dir = DIR_90;
        end else if (gx[11] == gy[11]) begin
            dir = DIR_45;
        end else begin
            dir = DIR_135;
        end
    end
endmodule

// File: rtl/sobel4_grad.sv
module sobel4_grad
    import sobel4_pkg::*;
#(
    parameter int IMG_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sof,
    input  logic                in_eol,
    input  logic                in_eof,
    input  logic [WORD_W-1:0]   in_data,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_mag,
    output logic [2*LANES-1:0]  out_dir
);
    localparam int WPL = IMG_W / LANES;
    localparam int WA  = $clog2(WPL);
    localparam int FW  = $clog2(WPL + 1);
    localparam int NLINES = ROWS - 1;
    localparam logic [FW-1:0] F_DUMMY = FW'(WPL);
    localparam logic [FW-1:0] F_LAST  = FW'(WPL - 1);

    typedef struct packed {
        logic [1:0]          row;
        logic [WA-1:0]       wcnt;
        logic                flush;
        logic [FW-1:0]       fcnt;
        logic                s1_vld;
        logic                s1_wr;
        logic                s1_first;
        logic                s1_last;
        logic                s1_emit;
        logic                s1_top;
        logic [WA-1:0]       s1_addr;
        logic [WORD_W-1:0]   s1_data;
        logic                b_emit;
        logic                b_first;
        logic                b_last;
        logic [WORD_W-1:0]   b_t;
        logic [WORD_W-1:0]   b_m;
        logic [WORD_W-1:0]   b_b;
        logic [3*PIX_W-1:0]  a_edge;
        logic                o_vld;
        logic [WORD_W-1:0]   o_mag;
        logic [2*LANES-1:0]  o_dir;
    } st_t;

    st_t st_d, st_q;

    logic              rd_en;
    logic [WA-1:0]     rd_addr;
    logic [WORD_W-1:0] rd_data [NLINES];
    logic [WORD_W-1:0] wr_data [NLINES];
    logic [WORD_W-1:0] c_t, c_m, c_b;
    logic [6*PIX_W-1:0] win_t, win_m, win_b;

    logic [PIX_W-1:0]  kmag [LANES];
    dir_e              kdir [LANES];
    logic signed [11:0] kgx [LANES];
    logic signed [11:0] kgy [LANES];

    // line cache: entry 0 holds the newest line, entry 1 the one before
    assign wr_data[0] = st_q.s1_data;
    assign wr_data[1] = rd_data[0];

    for (genvar l = 0; l < NLINES; l++) begin : g_line
        s4_line_mem #(.DEPTH(WPL), .DW(WORD_W)) u_line (
            .clk   (clk),
            .we    (st_q.s1_vld && st_q.s1_wr),
            .waddr (st_q.s1_addr),
            .wdata (wr_data[l]),
            .re    (rd_en),
            .raddr (rd_addr),
            .rdata (rd_data[l])
        );
    end

    // column triplet of the word now in stage 1; top row black on a frame's first line
    assign c_t = st_q.s1_top ? '0 : rd_data[1];
    assign c_m = rd_data[0];
    assign c_b = st_q.s1_data;

    // shared 3x6 window: column 0 from the previous word, 1..4 the centre word, 5 the next word
    assign win_t = {(st_q.b_last ? {PIX_W{1'b0}} : c_t[PIX_W-1:0]), st_q.b_t,
                    (st_q.b_first ? {PIX_W{1'b0}} : st_q.a_edge[PIX_W-1:0])};
    assign win_m = {(st_q.b_last ? {PIX_W{1'b0}} : c_m[PIX_W-1:0]), st_q.b_m,
                    (st_q.b_first ? {PIX_W{1'b0}} : st_q.a_edge[2*PIX_W-1:PIX_W])};
    assign win_b = {(st_q.b_last ? {PIX_W{1'b0}} : c_b[PIX_W-1:0]), st_q.b_b,
                    (st_q.b_first ? {PIX_W{1'b0}} : st_q.a_edge[3*PIX_W-1:2*PIX_W])};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        s4_kernel u_kern (
            .t0  (win_t[PIX_W*k +: PIX_W]),
            .t1  (win_t[PIX_W*(k+1) +: PIX_W]),
            .t2  (win_t[PIX_W*(k+2) +: PIX_W]),
            .m0  (win_m[PIX_W*k +: PIX_W]),
            .m2  (win_m[PIX_W*(k+2) +: PIX_W]),
            .b0  (win_b[PIX_W*k +: PIX_W]),
            .b1  (win_b[PIX_W*(k+1) +: PIX_W]),
            .b2  (win_b[PIX_W*(k+2) +: PIX_W]),
            .mag (kmag[k]),
            .dir (kdir[k]),
            .gx  (kgx[k]),
            .gy  (kgy[k])
        );

        // R3: a diagonal code needs both derivatives non-zero
        p_diag_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (kdir[k] == DIR_45 || kdir[k] == DIR_135) |-> (kgx[k] != 0 && kgy[k] != 0));
        // R2: a flat neighbourhood gives zero magnitude and code 0
        p_zero_grad_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (kgx[k] == 0 && kgy[k] == 0) |-> (kmag[k] == '0 && kdir[k] == DIR_0));
    end

    always_comb begin
        logic [1:0]    cur_row;
        logic [WA-1:0] cur_w;
        logic          dummy;
        st_d    = st_q;
        st_d.s1_vld = 1'b0;
        st_d.s1_wr  = 1'b0;
        st_d.o_vld  = 1'b0;
        rd_en   = 1'b0;
        rd_addr = '0;
        cur_row = in_sof ? 2'd0 : st_q.row;
        cur_w   = in_sof ? '0 : st_q.wcnt;
        dummy   = (st_q.fcnt == F_DUMMY);

        // stage 0: accept a word or generate a flush step
        if (in_valid && !st_q.flush) begin
            st_d.s1_vld   = 1'b1;
            st_d.s1_wr    = 1'b1;
            st_d.s1_data  = in_data;
            st_d.s1_addr  = cur_w;
            st_d.s1_first = (cur_w == '0);
            st_d.s1_last  = in_eol;
            st_d.s1_emit  = (cur_row != 2'd0);
            st_d.s1_top   = (cur_row == 2'd1);
            rd_en   = 1'b1;
            rd_addr = cur_w;
            if (in_eol) begin
                st_d.wcnt = '0;
                st_d.row  = (cur_row == 2'd2) ? 2'd2 : cur_row + 2'd1;
            end else begin
                st_d.wcnt = cur_w + 1'b1;
            end
            if (in_eof) begin
                st_d.flush = 1'b1;
                st_d.fcnt  = '0;
            end
        end else if (st_q.flush) begin
            st_d.s1_vld   = 1'b1;
            st_d.s1_data  = '0;
            st_d.s1_addr  = dummy ? '0 : st_q.fcnt[WA-1:0];
            st_d.s1_first = (st_q.fcnt == '0);
            st_d.s1_last  = (st_q.fcnt == F_LAST);
            st_d.s1_emit  = !dummy;
            st_d.s1_top   = (st_q.row == 2'd1);
            rd_en   = 1'b1;
            rd_addr = dummy ? '0 : st_q.fcnt[WA-1:0];
            if (dummy) begin
                st_d.flush = 1'b0;
                st_d.row   = 2'd0;
            end else begin
                st_d.fcnt = st_q.fcnt + 1'b1;
            end
        end

        // stage 1: evaluate the centre word, then shift the window by one word
        if (st_q.s1_vld) begin
            st_d.o_vld = st_q.b_emit;
            if (st_q.b_emit) begin
                for (int k = 0; k < LANES; k++) begin
                    st_d.o_mag[PIX_W*k +: PIX_W] = kmag[k];
                    st_d.o_dir[2*k +: 2]         = kdir[k];
                end
            end
            st_d.a_edge  = {st_q.b_b[WORD_W-1 -: PIX_W], st_q.b_m[WORD_W-1 -: PIX_W],
                            st_q.b_t[WORD_W-1 -: PIX_W]};
            st_d.b_t     = c_t;
            st_d.b_m     = c_m;
            st_d.b_b     = c_b;
            st_d.b_emit  = st_q.s1_emit;
            st_d.b_first = st_q.s1_first;
            st_d.b_last  = st_q.s1_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o_vld;
    assign out_mag   = st_q.o_mag;
    assign out_dir   = st_q.o_dir;

    // R6: the sender keeps the input idle while the last line drains
    p_no_input_in_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flush |-> !in_valid);
    // R6: the flush counter never runs past the extra shift step
    p_flush_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flush |-> (st_q.fcnt <= F_DUMMY));
    // R5: a result only ever follows a window shift
    p_out_after_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.o_vld |-> $past(st_q.s1_vld));
endmodule

// File: tb/tb_sobel4_grad.sv
module tb_sobel4_grad;
    localparam int W   = 16;
    localparam int WPL = W / 4;
    localparam int HMAX = 8;

    typedef struct {
        logic [31:0] mag;
        logic [7:0]  dir;
        int          row;
        int          word;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, in_eof = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_mag;
    logic [7:0]  out_dir;

    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    bit   row0_phase = 1'b0;
    bit   early_seen = 1'b0;
    int   img [HMAX][W];
    int   fh;
    exp_t exp_q [$];

    always #10 clk = ~clk;

    sobel4_grad #(.IMG_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eol(in_eol), .in_eof(in_eof), .in_data(in_data),
        .out_valid(out_valid), .out_mag(out_mag), .out_dir(out_dir)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic int px(input int y, input int x);
        if (y < 0 || y >= fh || x < 0 || x >= W) return 0;  // R4 black border
        return img[y][x];
    endfunction

    function automatic int pat(input int p, input int y, input int x);
        case (p)
            0: return 100;
            1: return (x >= 7) ? 200 : 10;
            2: return (y >= 3) ? 180 : 20;
            3: return (x + y >= 8) ? 150 : 0;
            4: return ((x * 37 + y * 91 + x * y * 13) ^ 8'h5A) & 255;
            5: return x * 16;
            6: return (x - y >= 2) ? 120 : 0;
            default: return ((x * 59 + y * 17) ^ 8'hC3) & 255;
        endcase
    endfunction

    // reference of R2/R3 computed from the requirement text
    task automatic ref_pixel(input int y, input int x, output int mag, output int dir);
        int gx, gy, ax, ay;
        gx = (px(y-1,x+1) + 2*px(y,x+1) + px(y+1,x+1)) - (px(y-1,x-1) + 2*px(y,x-1) + px(y+1,x-1));
        gy = (px(y+1,x-1) + 2*px(y+1,x) + px(y+1,x+1)) - (px(y-1,x-1) + 2*px(y-1,x) + px(y-1,x+1));
        ax = (gx < 0) ? -gx : gx;
        ay = (gy < 0) ? -gy : gy;
        mag = (ax + ay > 255) ? 255 : ax + ay;
        if (128 * ay <= 53 * ax) dir = 0;
        else if (128 * ay >= 309 * ax) dir = 2;
        else if ((gx > 0) == (gy > 0)) dir = 1;
        else dir = 3;
    endtask

    task automatic send_frame(input int h, input int p, input bit gaps);
        fh = h;
        for (int y = 0; y < h; y++)
            for (int x = 0; x < W; x++) img[y][x] = pat(p, y, x);
        for (int y = 0; y < h; y++) begin
            for (int w = 0; w < WPL; w++) begin
                exp_t e;
                e.row = y; e.word = w; e.mag = '0; e.dir = '0;
                for (int k = 0; k < 4; k++) begin
                    int m, d;
                    ref_pixel(y, 4*w + k, m, d);
                    e.mag[8*k +: 8] = 8'(m);   // R1 lane packing
                    e.dir[2*k +: 2] = 2'(d);
                end
                exp_q.push_back(e);
            end
        end
        row0_phase = 1'b1;
        early_seen = 1'b0;
        for (int y = 0; y < h; y++) begin
            for (int w = 0; w < WPL; w++) begin
                if (gaps && ((y * WPL + w) % 3 == 1)) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    repeat ((y + w) % 2) @(negedge clk);
                end
                @(negedge clk);
                in_valid = 1'b1;
                in_sof = (y == 0 && w == 0);
                in_eol = (w == WPL - 1);
                in_eof = (y == h - 1 && w == WPL - 1);
                for (int k = 0; k < 4; k++) in_data[8*k +: 8] = 8'(img[y][4*w + k]);
            end
            if (y == 0) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_eof = 1'b0;
                row0_phase = 1'b0;
                // R5: no output while the first line of the frame arrives
                check(!early_seen, "R5", "output during first line", 32'(early_seen), 32'd0);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_eof = 1'b0;
        // R6: the last line drains without further input
        for (int i = 0; i < 4 * WPL + 20 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R6", "words missing after flush", 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        repeat (3) @(negedge clk);
    endtask

    // scoreboard monitor: R1 R2 R3 R4 R5 R7 per output word
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (row0_phase) early_seen = 1'b1;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected output word", out_mag, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_mag === e.mag, "R2 R4",
                      $sformatf("mag row %0d word %0d", e.row, e.word), out_mag, e.mag);
                check(out_dir === e.dir, "R3 R4",
                      $sformatf("dir row %0d word %0d", e.row, e.word), 32'(out_dir), 32'(e.dir));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: idle after reset
        check(out_valid == 1'b0, "R8", "out_valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8", "out_valid idle after reset", 32'(out_valid), 32'd0);
        send_frame(6, 0, 1'b0);   // R4 flat frame: only borders non-zero
        send_frame(6, 1, 1'b1);   // vertical edge, gaps in input
        send_frame(5, 2, 1'b0);   // horizontal edge
        send_frame(8, 3, 1'b1);   // R3 45-degree diagonal
        send_frame(6, 6, 1'b0);   // R3 135-degree diagonal
        send_frame(6, 4, 1'b0);   // bright texture, saturation R2
        send_frame(1, 5, 1'b0);   // R7 restart after bright frame, single line R6
        send_frame(2, 7, 1'b1);   // two-line frame R6 R7
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule